// File: doc/BRIEF.md
# Sixteen-Bit Capture / Reload Timer

This block is a 16-bit up-counter with one shared 16-bit holding register whose role depends on the operating mode. In capture mode, a falling edge on the capture pin snapshots the running count into the holding register. In reload mode, the holding register is the start value that the counter takes again after it wraps. In baud mode, the counter also reloads on wrap, but each wrap sends a single-cycle rate pulse to a serial port instead of raising the overflow flag.

The counter advances on one of three sources. It can count every clock, count once in every twelve clocks, or count falling edges seen on an external count pin. Both pins pass through a two-flop synchronizer before edge detection. Software reaches the block through a byte-wide write port and a combinational read port. An interrupt request combines the overflow flag and the external-edge flag under a single enable.

Top module: `cap_reload_timer`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), every register reads 0x00, `irq` is 0 and `baud_tick` is 0.
- R2: The count is read and written as two bytes: address 2 holds bits 7:0 and address 3 holds bits 15:8. A byte write replaces only that byte of the count. In a cycle where software writes the count, the write takes priority over any increment.
- R3: The control register sits at address 0. When its bit 1 is 1, the count advances once per falling edge of `cnt_pin`, acted on at the third clock edge after the pin is sampled low. When bit 1 is 0, the count follows bit 2: it advances every cycle when bit 2 is 1, and once every 12 cycles when bit 2 is 0.
- R4: Capture mode is selected when control bits 4:3 are 00. In this mode a falling edge on `cap_pin` copies the count into the holding register (address 4 holds bits 7:0, address 5 holds bits 15:8) and sets the external flag (control bit 7). Rising edges are ignored. In any other mode, edges on `cap_pin` change nothing.
- R5: Reload mode is selected when control bits 4:3 are 01. When the count advances from 0xFFFF, it loads the holding register and the overflow flag (control bit 6) is set.
- R6: In capture mode, when the count advances from 0xFFFF, it becomes 0x0000 and the overflow flag is set.
- R7: Baud mode is selected when control bit 4 is 1. On wrap, the count reloads from the holding register and the overflow flag is left unchanged. `baud_tick` is 1 for exactly the cycle after the clock edge at which the wrap occurs.
- R8: Control bit 0 is the run bit. While it is 0 the count holds its value. Setting it to 1 resumes counting from the held value, without clearing it.
- R9: The overflow and external flags stay set until software writes a 0 to the flag bit. Software can also write a 1 to a flag bit. When a hardware set and a software write land in the same cycle, the hardware set wins.
- R10: `irq` is 1 exactly when control bit 5 (interrupt enable) is 1 and at least one of the two flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for both read and write |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `addr` (combinational) |
| cap_pin | input | 1 | External capture input (asynchronous) |
| cnt_pin | input | 1 | External count input (asynchronous) |
| irq | output | 1 | Interrupt request |
| baud_tick | output | 1 | One-cycle rate pulse per wrap in baud mode |

## Verification
The counter is exercised with each of the three sources: the full-rate clock, the divide-by-12 clock, and short pulses on the count pin. These runs show whether the source select and the prescale phase are right. Starting the count just below 0xFFFF in each mode separates the three wrap behaviours: clear to zero with the flag set, reload with the flag set, and reload with a pulse and no flag. Falling and rising edges are applied to the capture pin in capture mode and again in reload mode, which confirms that only a falling edge in capture mode takes a snapshot. Flag writes with the enable both on and off check that the flags stay set and that the interrupt is masked correctly.

// File: rtl/crt_pkg.sv
package crt_pkg;

  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_CAPTURE  = 2'b00,
    MODE_RELOAD   = 2'b01,
    MODE_BAUD     = 2'b10,
    MODE_BAUD_ALT = 2'b11
  } tmr_mode_e;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_CNT_LO = 3'd2;
  localparam logic [2:0] ADDR_CNT_HI = 3'd3;
  localparam logic [2:0] ADDR_CAP_LO = 3'd4;
  localparam logic [2:0] ADDR_CAP_HI = 3'd5;

  // Control byte, MSB first
  typedef struct packed {
    logic       ext_flag;
    logic       ovf_flag;
    logic       irq_en;
    logic [1:0] mode;
    logic       clk_full;
    logic       ext_src;
    logic       run;
  } ctrl_t;

  // Replace one byte of a 16-bit word
  function automatic logic [CNT_W-1:0] put_byte(input logic [CNT_W-1:0] cur,
                                                input logic hi,
                                                input logic [BYTE_W-1:0] b);
    return hi ? {b, cur[BYTE_W-1:0]} : {cur[CNT_W-1:BYTE_W], b};
  endfunction

  // Value after one increment; on wrap either zero or the reload word
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic reload,
                                                  input logic [CNT_W-1:0] rl);
    if (cur == {CNT_W{1'b1}}) return reload ? rl : '0;
    return cur + 1'b1;
  endfunction

endpackage

// File: rtl/crt_edge_sync.sv
module crt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/crt_prescale.sv
module crt_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = $clog2(DIV);
  logic [W-1:0] cnt;

  assign tick = (cnt == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
  parameter int PRE_DIV     = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [2:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cap_pin,
  input  logic       cnt_pin,
  output logic       irq,
  output logic       baud_tick
);
  import crt_pkg::*;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] cap_reg;
  logic             baud_q;

  logic cap_fall, cnt_fall, pre_tick;
  logic ctrl_wr, cnt_wr, cap_wr;
  logic src_tick, inc_evt, ovf_evt, cap_evt, baud_mode;

  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst(rst), .din(cap_pin), .fall(cap_fall));
  crt_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
    .clk(clk), .rst(rst), .din(cnt_pin), .fall(cnt_fall));
  crt_prescale #(.DIV(PRE_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick(pre_tick));

  // Named internal events
  assign ctrl_wr   = wr_en && (addr == ADDR_CTRL);
  assign cnt_wr    = wr_en && (addr == ADDR_CNT_LO || addr == ADDR_CNT_HI);
  assign cap_wr    = wr_en && (addr == ADDR_CAP_LO || addr == ADDR_CAP_HI);
  assign baud_mode = ctrl.mode[1];
  assign src_tick  = ctrl.ext_src ? cnt_fall : (ctrl.clk_full | pre_tick);
  assign inc_evt   = ctrl.run & src_tick;
  assign ovf_evt   = inc_evt & (count == {CNT_W{1'b1}});
  assign cap_evt   = (ctrl.mode == MODE_CAPTURE) & cap_fall;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (cnt_wr)  count <= put_byte(count, addr == ADDR_CNT_HI, wdata);
    else if (inc_evt) count <= next_count(count, ctrl.mode != MODE_CAPTURE, cap_reg);
  end

  always_ff @(posedge clk) begin
    if (rst)          cap_reg <= '0;
    else if (cap_wr)  cap_reg <= put_byte(cap_reg, addr == ADDR_CAP_HI, wdata);
    else if (cap_evt) cap_reg <= count;
  end

  // Hardware flag sets come last so they override a same-cycle write
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (ctrl_wr)                ctrl          <= ctrl_t'(wdata);
      if (ovf_evt && !baud_mode)  ctrl.ovf_flag <= 1'b1;
      if (cap_evt)                ctrl.ext_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) baud_q <= 1'b0;
    else     baud_q <= ovf_evt & baud_mode;
  end

  assign baud_tick = baud_q;
  assign irq       = ctrl.irq_en & (ctrl.ovf_flag | ctrl.ext_flag);

  always_comb begin
    case (addr)
      ADDR_CTRL:   rdata = ctrl;
      ADDR_CNT_LO: rdata = count[BYTE_W-1:0];
      ADDR_CNT_HI: rdata = count[CNT_W-1:BYTE_W];
      ADDR_CAP_LO: rdata = cap_reg[BYTE_W-1:0];
      ADDR_CAP_HI: rdata = cap_reg[CNT_W-1:BYTE_W];
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/crt_checker.sv
module crt_checker (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        baud_tick,
  input logic        ovf_evt,
  input logic        cap_evt,
  input logic        baud_mode,
  input logic        ovf_flag,
  input logic        ext_flag,
  input logic        irq_en,
  input logic        run,
  input logic        cnt_wr,
  input logic        ctrl_wr,
  input logic [15:0] count
);
  a_r7_baud_pulse: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && baud_mode) |=> baud_tick);

  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !baud_mode) |=> ovf_flag);

  a_r4_capture_flag: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> ext_flag);

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_flag && !ctrl_wr) |=> ovf_flag);

  a_r9_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    (ext_flag && !ctrl_wr) |=> ext_flag);

  a_r8_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count));

  a_r10_masked: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_en);
endmodule

bind cap_reload_timer crt_checker u_chk (
  .clk(clk), .rst(rst), .irq(irq), .baud_tick(baud_tick),
  .ovf_evt(ovf_evt), .cap_evt(cap_evt), .baud_mode(baud_mode),
  .ovf_flag(ctrl.ovf_flag), .ext_flag(ctrl.ext_flag), .irq_en(ctrl.irq_en),
  .run(ctrl.run), .cnt_wr(cnt_wr), .ctrl_wr(ctrl_wr), .count(count));

// File: tb/sim_cap_reload_timer.sv
module sim_cap_reload_timer;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic       cap_pin = 1'b1, cnt_pin = 1'b1;
  logic [7:0] rdata;
  logic       irq, baud_tick;

  int n_chk = 0, n_bad = 0;
  bit started = 0, done = 0;

  always #(CLK_P/2) clk = ~clk;

  cap_reload_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .cap_pin(cap_pin), .cnt_pin(cnt_pin),
    .irq(irq), .baud_tick(baud_tick));

  // Behavioural reference model
  logic [15:0] m_cnt, m_cap;
  logic        m_run, m_ext, m_full, m_ien, m_ovf, m_exf, m_baud;
  logic [1:0]  m_mode;
  int          m_pre;
  int          hc[3], hn[3];

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cap = 0; m_run = 0; m_ext = 0; m_full = 0; m_ien = 0;
      m_ovf = 0; m_exf = 0; m_mode = 0; m_baud = 0; m_pre = 0;
      for (int i = 0; i < 3; i++) begin hc[i] = 1; hn[i] = 1; end
    end else begin
      bit cfall, nfall, pt, tk, inc, wrap, capev;
      logic [15:0] n_cnt, n_cap;
      cfall = (hc[1] == 0) && (hc[2] == 1);
      nfall = (hn[1] == 0) && (hn[2] == 1);
      pt    = (m_pre == 11);
      tk    = m_ext ? nfall : (m_full || pt);
      inc   = m_run && tk;
      wrap  = inc && (m_cnt == 16'hFFFF);
      capev = (m_mode == 2'b00) && cfall;
      n_cnt = m_cnt;
      n_cap = m_cap;
      if (inc) n_cnt = wrap ? ((m_mode != 2'b00) ? m_cap : 16'h0) : m_cnt + 16'd1;
      if (capev) n_cap = m_cnt;
      if (wr_en) begin
        case (addr)
          3'd0: {m_exf, m_ovf, m_ien, m_mode, m_full, m_ext, m_run} = wdata;
          3'd2: n_cnt = {m_cnt[15:8], wdata};
          3'd3: n_cnt = {wdata, m_cnt[7:0]};
          3'd4: n_cap = {m_cap[15:8], wdata};
          3'd5: n_cap = {wdata, m_cap[7:0]};
          default: ;
        endcase
      end
      if (wrap && !m_mode[1] && !(wr_en && addr == 3'd0 && wdata[4])) m_ovf = 1;
      if (wrap && !m_mode[1] && wr_en && addr == 3'd0 && wdata[4]) m_ovf = 1;
      if (capev) m_exf = 1;
      m_baud = wrap && m_mode[1];
      m_cnt = n_cnt;
      m_cap = n_cap;
      hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = cap_pin;
      hn[2] = hn[1]; hn[1] = hn[0]; hn[0] = cnt_pin;
      m_pre = pt ? 0 : m_pre + 1;
    end
    started = 1;
  end

  function automatic logic [7:0] model_reg(input logic [2:0] a);
    case (a)
      3'd0: return {m_exf, m_ovf, m_ien, m_mode, m_full, m_ext, m_run};
      3'd2: return m_cnt[7:0];
      3'd3: return m_cnt[15:8];
      3'd4: return m_cap[7:0];
      3'd5: return m_cap[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of the pin outputs
  always @(negedge clk) begin
    if (started && !rst && !done) begin
      chk(irq == (m_ien && (m_ovf || m_exf)), "R10 irq", int'(irq),
          int'(m_ien && (m_ovf || m_exf)));
      chk(baud_tick == m_baud, "R7 baud_tick", int'(baud_tick), int'(m_baud));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    addr = a;
    #1;
    chk(rdata == model_reg(a), tag, int'(rdata), int'(model_reg(a)));
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    idle(3);
    // R1: reset state, with a hand value as well as the model
    for (int a = 0; a < 6; a++) begin
      addr = 3'(a); #1;
      chk(rdata == 8'h00, "R1 reset value", int'(rdata), 0);
    end
    chk(irq == 0 && baud_tick == 0, "R1 reset outputs", int'({irq, baud_tick}), 0);
    rst = 1'b0;
    idle(2);

    // R2: byte write and readback, timer stopped (R8 hold)
    wr(3'd2, 8'h34); wr(3'd3, 8'h12);
    idle(4);
    rd(3'd2, "R2 count low"); rd(3'd3, "R2 count high");
    chk({rdata} == 8'h12, "R8 count held while stopped", int'(rdata), 8'h12);

    // R3 full-rate + R6 capture-mode wrap + R8 run keeps preset
    wr(3'd2, 8'hF8); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h25);
    idle(12);
    rd(3'd2, "R6 count after wrap"); rd(3'd3, "R6 count high");
    rd(3'd0, "R6 overflow flag");
    // R9: write zero to the flag, stop counting
    wr(3'd0, 8'h24);
    rd(3'd0, "R9 flag cleared");
    idle(5);
    rd(3'd2, "R8 held after stop");
    // R2: write while running has priority
    wr(3'd0, 8'h25);
    wr(3'd2, 8'h80);
    rd(3'd2, "R2 write priority");

    // R3 divided clock
    wr(3'd0, 8'h21);
    idle(30);
    rd(3'd2, "R3 divided count"); rd(3'd3, "R3 divided count high");

    // R3 external count pin
    wr(3'd0, 8'h23);
    for (int p = 0; p < 5; p++) begin
      cnt_pin = 1'b0; idle(2);
      cnt_pin = 1'b1; idle(2);
    end
    idle(4);
    rd(3'd2, "R3 external count");

    // R4 capture on falling edge, ignored on rising
    wr(3'd0, 8'h25);
    idle(4);
    cap_pin = 1'b0; idle(5);
    rd(3'd4, "R4 capture low"); rd(3'd5, "R4 capture high");
    rd(3'd0, "R4 external flag");
    cap_pin = 1'b1; idle(6);
    rd(3'd4, "R4 rising edge ignored");
    wr(3'd0, 8'h25);
    rd(3'd0, "R9 external flag cleared");

    // R5 reload mode
    wr(3'd0, 8'h24);
    wr(3'd4, 8'h00); wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFC); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h2D);
    idle(6);
    rd(3'd2, "R5 reload low"); rd(3'd3, "R5 reload high");
    rd(3'd0, "R5 overflow flag");
    cap_pin = 1'b0; idle(5);
    rd(3'd4, "R4 no capture in reload mode");
    cap_pin = 1'b1; idle(3);

    // R7 baud mode
    wr(3'd0, 8'h14);
    wr(3'd4, 8'hFA); wr(3'd5, 8'hFF);
    wr(3'd2, 8'hFD); wr(3'd3, 8'hFF);
    wr(3'd0, 8'h15);
    idle(20);
    rd(3'd0, "R7 no overflow flag in baud mode");
    rd(3'd2, "R7 baud reload count");

    // R10 masking, R9 software set
    wr(3'd0, 8'h40);
    idle(2);
    rd(3'd0, "R9 software set");
    chk(irq == 1'b0, "R10 masked irq", int'(irq), 0);
    wr(3'd0, 8'h60);
    idle(1);
    chk(irq == 1'b1, "R10 enabled irq", int'(irq), 1);

    idle(3);
    finish_run();
  end
endmodule